// File: doc/BRIEF.md
# Rename Dispatch Credit Tracker

This block sits beside the rename stage of an out-of-order core. Each hardware thread gets three credit budgets, one for each downstream structure: the reorder buffer, the issue queue and the load/store queue. Every cycle the block works out how many of the waiting instructions rename may pass on. It also tells rename whether to block, and which structure is the limiting one.

Downstream stages report their free entry counts only now and then, and each report carries a valid flag. The tracker keeps the last report for each structure. A report is out of date as soon as rename sends more instructions, so the block also counts instructions that have been renamed but not yet dispatched. Each budget is the stored free count minus that in-flight count, with the dispatches of the current cycle credited back. The tightest of the three budgets sets the grant. The grant is also capped by the rename width.

The tracker also keeps one wrapping full-event counter for each structure and thread. It also keeps a per-thread flag that holds the last empty state reported by the reorder buffer.

Top module: `rename_credit_tracker`

## Requirements
- R1: For each thread, the reorder-buffer budget and the issue-queue budget are each the stored free count minus (in-flight count minus `disp_all`). All values are taken as signed integers.
- R2: The load/store-queue budget is the stored load/store free count minus (in-flight count minus `disp_mem`). It uses `disp_mem` in place of `disp_all`.
- R3: The limit code `limit_src` is 0 for the reorder buffer, 1 for the issue queue and 2 for the load/store queue. It starts at 0. It becomes 1 only if the issue-queue budget is strictly below the reorder-buffer budget. It then becomes 2 only if the load/store budget is strictly below the current minimum.
- R4: When `avail` is nonzero and the minimum budget is zero or negative, `grant` is 0 and `block_req` is 1. The full-event counter of the limiting structure then increases by one at the next clock edge.
- R5: When `avail` is nonzero and the minimum budget is positive but less than `avail`, `grant` is the smaller of the budget and WIDTH (default 4). In this case `block_req` is 1 and the limiting structure's event counter increases by one at the next edge.
- R6: When the minimum budget is at least `avail`, `grant` is the smaller of `avail` and WIDTH, and `block_req` is 0. When `avail` is 0, `grant` and `block_req` are both 0. In neither case does any event counter change.
- R7: A stored free count is replaced only at an edge where its valid bit is 1. On a reorder-buffer report, `rob_empty` also takes the value of `rob_rpt_empty`. Without a valid bit, the stored count and the flag keep their values.
- R8: At each edge, `inflight` becomes `inflight + renamed - disp_all`. It must never go below zero.
- R9: After reset, all stored free counts, the in-flight counts and the event counters are 0, and `rob_empty` is 1 for every thread.
- R10: Each thread's state and outputs depend only on that thread's slice of the inputs. Thread t occupies bits [t*W +: W] of each packed bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rob_rpt_vld | input | THREADS | Reorder-buffer report valid, per thread |
| rob_rpt_free | input | THREADS*CW | Reported reorder-buffer free entries |
| rob_rpt_empty | input | THREADS | Reported reorder-buffer empty state |
| iq_rpt_vld | input | THREADS | Issue-queue report valid |
| iq_rpt_free | input | THREADS*CW | Reported issue-queue free entries |
| lsq_rpt_vld | input | THREADS | Load/store-queue report valid |
| lsq_rpt_free | input | THREADS*CW | Reported load/store-queue free entries |
| disp_all | input | THREADS*CW | Instructions dispatched this cycle |
| disp_mem | input | THREADS*CW | Memory instructions dispatched this cycle |
| renamed | input | THREADS*CW | Instructions renamed this cycle |
| avail | input | THREADS*CW | Instructions waiting to be renamed |
| grant | output | THREADS*CW | Instructions allowed to be renamed |
| block_req | output | THREADS | Block request toward earlier stages |
| limit_src | output | THREADS*2 | Limiting structure code (0 ROB, 1 IQ, 2 LSQ) |
| rob_empty | output | THREADS | Last reported reorder-buffer empty flag |
| inflight | output | THREADS*CW | Renamed but not yet dispatched count |
| rob_full_evt | output | THREADS*EW | Reorder-buffer full events |
| iq_full_evt | output | THREADS*EW | Issue-queue full events |
| lsq_full_evt | output | THREADS*EW | Load/store-queue full events |

## Verification
A wrong in-flight count or a wrong stored free count shifts all three budgets. It therefore shows up in the same cycle as a wrong `grant`, `block_req` or `limit_src`, as soon as `avail` is nonzero and the budget is near the limit. The in-flight count is also visible on `inflight` one edge after the bad update. A wrong tie order or an event credited to the wrong structure shows on `limit_src` in the same cycle and on the event counters one edge later. Because the reference model is compared on every clock, a divergence is caught in the cycle it first reaches a port.

// File: rtl/rename_credit_tracker.sv
module rename_credit_tracker #(
  parameter int THREADS = 2,
  parameter int CW      = 6,
  parameter int WIDTH   = 4,
  parameter int EW      = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [THREADS-1:0]    rob_rpt_vld,
  input  logic [THREADS*CW-1:0] rob_rpt_free,
  input  logic [THREADS-1:0]    rob_rpt_empty,
  input  logic [THREADS-1:0]    iq_rpt_vld,
  input  logic [THREADS*CW-1:0] iq_rpt_free,
  input  logic [THREADS-1:0]    lsq_rpt_vld,
  input  logic [THREADS*CW-1:0] lsq_rpt_free,
  input  logic [THREADS*CW-1:0] disp_all,
  input  logic [THREADS*CW-1:0] disp_mem,
  input  logic [THREADS*CW-1:0] renamed,
  input  logic [THREADS*CW-1:0] avail,
  output logic [THREADS*CW-1:0] grant,
  output logic [THREADS-1:0]    block_req,
  output logic [THREADS*2-1:0]  limit_src,
  output logic [THREADS-1:0]    rob_empty,
  output logic [THREADS*CW-1:0] inflight,
  output logic [THREADS*EW-1:0] rob_full_evt,
  output logic [THREADS*EW-1:0] iq_full_evt,
  output logic [THREADS*EW-1:0] lsq_full_evt
);
  localparam int B = CW + 2;
  localparam logic signed [B-1:0] WID_S = B'(WIDTH);

  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    logic [CW-1:0] rob_q, iq_q, lsq_q, infl_q;
    logic [EW-1:0] ev_rob_q, ev_iq_q, ev_lsq_q;
    logic          empty_q;

    logic signed [B-1:0] infl_s, dall_s, dmem_s, av_s, ren_s;
    logic signed [B-1:0] bud_rob, bud_iq, bud_lsq, bud_min, take, infl_nxt;
    logic [1:0]          src;
    logic                blk, evt;

    assign infl_s = $signed({2'b00, infl_q});
    assign dall_s = $signed({2'b00, disp_all[t*CW +: CW]});
    assign dmem_s = $signed({2'b00, disp_mem[t*CW +: CW]});
    assign av_s   = $signed({2'b00, avail[t*CW +: CW]});
    assign ren_s  = $signed({2'b00, renamed[t*CW +: CW]});

    assign bud_rob = $signed({2'b00, rob_q}) - (infl_s - dall_s);
    assign bud_iq  = $signed({2'b00, iq_q})  - (infl_s - dall_s);
    assign bud_lsq = $signed({2'b00, lsq_q}) - (infl_s - dmem_s);

    always_comb begin
      bud_min = bud_rob;
      src     = 2'd0;
      if (bud_iq < bud_min) begin
        bud_min = bud_iq;
        src     = 2'd1;
      end
      if (bud_lsq < bud_min) begin
        bud_min = bud_lsq;
        src     = 2'd2;
      end
    end

    always_comb begin
      take = '0;
      blk  = 1'b0;
      evt  = 1'b0;
      if (av_s != '0) begin
        if (bud_min <= 0) begin
          blk = 1'b1;
          evt = 1'b1;
        end else begin
          take = (bud_min < av_s) ? bud_min : av_s;
          if (bud_min < av_s) begin
            blk = 1'b1;
            evt = 1'b1;
          end
          if (take > WID_S) take = WID_S;
        end
      end
    end

    assign infl_nxt = infl_s + ren_s - dall_s;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rob_q    <= '0;
        iq_q     <= '0;
        lsq_q    <= '0;
        infl_q   <= '0;
        empty_q  <= 1'b1;
        ev_rob_q <= '0;
        ev_iq_q  <= '0;
        ev_lsq_q <= '0;
      end else begin
        if (rob_rpt_vld[t]) begin
          rob_q   <= rob_rpt_free[t*CW +: CW];
          empty_q <= rob_rpt_empty[t];
        end
        if (iq_rpt_vld[t])  iq_q  <= iq_rpt_free[t*CW +: CW];
        if (lsq_rpt_vld[t]) lsq_q <= lsq_rpt_free[t*CW +: CW];
        infl_q <= infl_nxt[CW-1:0];
        if (evt) begin
          case (src)
            2'd0:    ev_rob_q <= ev_rob_q + 1'b1;
            2'd1:    ev_iq_q  <= ev_iq_q + 1'b1;
            default: ev_lsq_q <= ev_lsq_q + 1'b1;
          endcase
        end
      end
    end

    assign grant[t*CW +: CW]        = take[CW-1:0];
    assign block_req[t]             = blk;
    assign limit_src[t*2 +: 2]      = src;
    assign rob_empty[t]             = empty_q;
    assign inflight[t*CW +: CW]     = infl_q;
    assign rob_full_evt[t*EW +: EW] = ev_rob_q;
    assign iq_full_evt[t*EW +: EW]  = ev_iq_q;
    assign lsq_full_evt[t*EW +: EW] = ev_lsq_q;

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      infl_nxt >= 0); // R8
    AST_GRANT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (grant[t*CW +: CW] <= avail[t*CW +: CW]) && (int'(grant[t*CW +: CW]) <= WIDTH)); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (avail[t*CW +: CW] == '0) |-> (grant[t*CW +: CW] == '0 && !block_req[t])); // R6
    AST_ROB_EVT: assert property (@(posedge clk) disable iff (!rst_n)
      (block_req[t] && limit_src[t*2 +: 2] == 2'd0) |=>
      rob_full_evt[t*EW +: EW] == EW'($past(rob_full_evt[t*EW +: EW]) + 1'b1)); // R4
    AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rob_rpt_vld[t] |=> $stable(rob_empty[t])); // R7
  end
endmodule

// File: tb/sim_rename_credit_tracker.sv
module sim_rename_credit_tracker;
  localparam int T = 2, CW = 6, W = 4, EW = 8;

  logic clk = 0, rst_n = 0;
  logic [T-1:0] rob_rpt_vld = '0, rob_rpt_empty = '0, iq_rpt_vld = '0, lsq_rpt_vld = '0;
  logic [T*CW-1:0] rob_rpt_free = '0, iq_rpt_free = '0, lsq_rpt_free = '0;
  logic [T*CW-1:0] disp_all = '0, disp_mem = '0, renamed = '0, avail = '0;
  logic [T*CW-1:0] grant, inflight;
  logic [T-1:0] block_req, rob_empty;
  logic [T*2-1:0] limit_src;
  logic [T*EW-1:0] rob_full_evt, iq_full_evt, lsq_full_evt;

  rename_credit_tracker #(.THREADS(T), .CW(CW), .WIDTH(W), .EW(EW)) u0 (.*);

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int rf[T], qf[T], lf[T], infl[T], emp[T], ev[T][3];
  int e_grant[T], e_blk[T], e_src[T];
  bit done = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int fld(logic [T*CW-1:0] v, int t);
    return int'(v[t*CW +: CW]);
  endfunction

  task automatic model_outputs();
    for (int t = 0; t < T; t++) begin
      int br, bq, bl, mn, av;
      br = rf[t] - (infl[t] - fld(disp_all, t));
      bq = qf[t] - (infl[t] - fld(disp_all, t));
      bl = lf[t] - (infl[t] - fld(disp_mem, t));
      mn = br; e_src[t] = 0;
      if (bq < mn) begin mn = bq; e_src[t] = 1; end
      if (bl < mn) begin mn = bl; e_src[t] = 2; end
      av = fld(avail, t);
      e_grant[t] = 0; e_blk[t] = 0;
      if (av != 0) begin
        if (mn <= 0) e_blk[t] = 1;
        else if (mn < av) begin e_blk[t] = 1; e_grant[t] = (mn < W) ? mn : W; end
        else e_grant[t] = (av < W) ? av : W;
      end
    end
  endtask

  task automatic compare_all();
    for (int t = 0; t < T; t++) begin
      chk($sformatf("R1/R2/R5/R6 grant t%0d", t), fld(grant, t), e_grant[t]);
      chk($sformatf("R4/R5/R6 block t%0d", t), int'(block_req[t]), e_blk[t]);
      chk($sformatf("R3 limit_src t%0d", t), int'(limit_src[t*2 +: 2]), e_src[t]);
      chk($sformatf("R7 rob_empty t%0d", t), int'(rob_empty[t]), emp[t]);
      chk($sformatf("R8 inflight t%0d", t), fld(inflight, t), infl[t]);
      chk($sformatf("R4 rob evt t%0d", t), int'(rob_full_evt[t*EW +: EW]), ev[t][0]);
      chk($sformatf("R5 iq evt t%0d", t), int'(iq_full_evt[t*EW +: EW]), ev[t][1]);
      chk($sformatf("R10 lsq evt t%0d", t), int'(lsq_full_evt[t*EW +: EW]), ev[t][2]);
    end
  endtask

  task automatic model_edge();
    for (int t = 0; t < T; t++) begin
      if (e_blk[t] != 0) ev[t][e_src[t]] = (ev[t][e_src[t]] + 1) % 256;
      if (rob_rpt_vld[t]) begin rf[t] = fld(rob_rpt_free, t); emp[t] = rob_rpt_empty[t]; end
      if (iq_rpt_vld[t])  qf[t] = fld(iq_rpt_free, t);
      if (lsq_rpt_vld[t]) lf[t] = fld(lsq_rpt_free, t);
      infl[t] = infl[t] + fld(renamed, t) - fld(disp_all, t);
    end
  endtask

  task automatic step();
    #1;
    model_outputs();
    compare_all();
    for (int t = 0; t < T; t++) renamed[t*CW +: CW] = CW'(fld(grant, t));
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic set_rpt(int t, int r, int q, int l, bit e);
    rob_rpt_vld[t] = 1; iq_rpt_vld[t] = 1; lsq_rpt_vld[t] = 1;
    rob_rpt_free[t*CW +: CW] = CW'(r);
    iq_rpt_free[t*CW +: CW]  = CW'(q);
    lsq_rpt_free[t*CW +: CW] = CW'(l);
    rob_rpt_empty[t] = e;
  endtask

  initial begin
    for (int t = 0; t < T; t++) begin
      rf[t] = 0; qf[t] = 0; lf[t] = 0; infl[t] = 0; emp[t] = 1;
      for (int k = 0; k < 3; k++) ev[t][k] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    model_outputs();
    compare_all();  // R9 reset state
    rst_n = 1;
    // R4: empty budgets with work waiting, tie resolves to reorder buffer
    avail[0 +: CW] = 6'd3;
    step();
    // R6/R7: equal reports, all reported at once
    set_rpt(0, 5, 5, 5, 0);
    step();
    rob_rpt_vld = '0; iq_rpt_vld = '0; lsq_rpt_vld = '0;
    avail[0 +: CW] = 6'd2;
    step();
    // R3: issue queue strictly smaller; then load/store tie keeps issue queue
    set_rpt(0, 9, 3, 3, 1);
    avail[0 +: CW] = 6'd0;
    step();
    rob_rpt_vld = '0; iq_rpt_vld = '0; lsq_rpt_vld = '0;
    avail[0 +: CW] = 6'd6;
    step();
    avail[0 +: CW] = 6'd6;
    step();
    // R2: load/store smaller, memory dispatch credited separately
    set_rpt(0, 20, 20, 2, 0);
    step();
    rob_rpt_vld = '0; iq_rpt_vld = '0; lsq_rpt_vld = '0;
    disp_all[0 +: CW] = 6'd1; disp_mem[0 +: CW] = 6'd0;
    step();
    disp_all = '0;
    // R10: thread 1 alone
    set_rpt(1, 30, 30, 30, 0);
    rob_rpt_vld[0] = 0; iq_rpt_vld[0] = 0; lsq_rpt_vld[0] = 0;
    avail = {6'd7, 6'd0};
    step();
    rob_rpt_vld = '0; iq_rpt_vld = '0; lsq_rpt_vld = '0;
    step();
    // Random traffic covering all requirements
    for (int c = 0; c < 4000; c++) begin
      for (int t = 0; t < T; t++) begin
        int d, m;
        rob_rpt_vld[t] = ($urandom_range(0, 3) == 0);
        iq_rpt_vld[t]  = ($urandom_range(0, 3) == 0);
        lsq_rpt_vld[t] = ($urandom_range(0, 3) == 0);
        rob_rpt_empty[t] = $urandom_range(0, 1);
        rob_rpt_free[t*CW +: CW] = CW'($urandom_range(0, 12));
        iq_rpt_free[t*CW +: CW]  = CW'($urandom_range(0, 12));
        lsq_rpt_free[t*CW +: CW] = CW'($urandom_range(0, 12));
        d = $urandom_range(0, infl[t]);
        m = $urandom_range(0, d);
        disp_all[t*CW +: CW] = CW'(d);
        disp_mem[t*CW +: CW] = CW'(m);
        avail[t*CW +: CW] = CW'($urandom_range(0, 7));
      end
      step();
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule